// File: doc/BRIEF.md
# Register-Immediate Integer ALU

A combinational integer execution unit for a small 32-bit register machine. Each evaluation takes an opcode, the value of a first source register, and a second operand. The second operand is either a second register value or a 16-bit immediate taken from the instruction and sign-extended. The unit returns a 32-bit result and three flags: a write enable for the destination register, an error flag, and a trap flag. It covers integer arithmetic, floor-rounded division and remainder, a three-way compare, bitwise operations including a native bit-clear, and logical and arithmetic shifts whose direction follows the sign of the shift amount.

One operation writes nothing. It is a bounds check that compares a third register value against a limit and raises the trap flag when the value falls outside the range. Every register-form operation has an immediate twin with the same behaviour, and the two differ only in one opcode bit. Opcodes that have no function assigned, and operands that the operation cannot take, raise the error flag and suppress the write.

The surrounding pipeline supplies the operands and commits `result_o` to the destination register only when `wr_en_o` is high. Fetch, writeback and memory access lie outside this block.

Top module: `alu_ri_core`

## Requirements
- R1: The opcode is 6 bits wide. Bits [3:0] select the function: 0 add, 1 subtract, 2 multiply, 3 divide, 4 modulo, 5 compare, 8 OR, 9 AND, 10 bit-clear, 11 XOR, 12 logical shift, 13 arithmetic shift, 14 bounds check. Bit 4 set selects the immediate form, in which the second operand is `imm_i` sign-extended to 32 bits and `rc_i` is ignored. Bit 4 clear selects the register form, in which the second operand is `rc_i` and `imm_i` is ignored. Bit 5 must be zero.
- R2: Add, subtract and multiply return the low 32 bits of the two's-complement result. Overflow never raises `err_o`.
- R3: Compare returns -1 (all ones), 0 or +1 according to the sign of the exact difference `rb_i` minus the second operand. The sign comes from the exact difference, not from the 32-bit wrapped one.
- R4: OR, AND and XOR combine `rb_i` with the second operand bit by bit. Bit-clear returns `rb_i` AND NOT second operand.
- R5: For both shift kinds, a positive amount shifts `rb_i` left and a negative amount shifts it right by the magnitude of the amount. A logical right shift fills the top bits with zeros. An arithmetic right shift copies the sign bit. A left shift fills the low bits with zeros. An amount of zero returns `rb_i` unchanged.
- R6: A shift amount below -31 or above +31 raises `err_o`, forces the result to 0 and holds `wr_en_o` low.
- R7: Divide rounds the quotient toward negative infinity. Modulo returns the matching remainder, which is zero or has the sign of the divisor. The one overflowing quotient, -2^31 divided by -1, returns -2^31 with a remainder of 0 and no error.
- R8: Divide or modulo by zero raises `err_o`, forces the result to 0 and holds `wr_en_o` low.
- R9: The bounds check raises `trap_o` when `ra_i` (signed) is negative or is greater than or equal to the second operand (signed). It always returns result 0 with `wr_en_o` low and `err_o` low. No other operation raises `trap_o`.
- R10: Any opcode with an unassigned function code (6, 7, 15) or with bit 5 set raises `err_o`, returns result 0 and holds `wr_en_o` low.
- R11: Every assigned operation other than the bounds check, given legal operands, has `err_o` low and `wr_en_o` high. A raised `err_o` always comes with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode: function code in [3:0], immediate select in bit 4 |
| ra_i | input | 32 | Value checked by the bounds check |
| rb_i | input | 32 | First source operand |
| rc_i | input | 32 | Second source operand in register form |
| imm_i | input | 16 | Immediate, sign-extended in immediate form |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result is to be written to the destination register |
| err_o | output | 1 | Illegal opcode or illegal operand |
| trap_o | output | 1 | Bounds check failed |

## Verification
The unit holds no state, so every output is due in the same cycle as its stimulus, with zero register stages between the inputs and `result_o` or the flags. The bench changes the inputs just after a rising clock edge and samples all four outputs at the following falling edge. That leaves half a period for the logic to settle and keeps the sample apart from the edge where the inputs change. Each directed scenario checks the result value and all three flags together. The corner operands are the wrap boundaries, the ±31 and ±32 shift amounts, mixed-sign division and the -2^31 / -1 quotient.

// File: rtl/alu_ri_pkg.sv
// Package: shared opcode field layout and decode record for the
// register-immediate ALU. Assumes the function code occupies the low four
// opcode bits and the immediate select sits just above it.
package alu_ri_pkg;

    localparam int FN_W    = 4;
    localparam int IMM_SEL = 4;   // opcode bit that selects the immediate form

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_MUL = 4'd2,
        FN_DIV = 4'd3,
        FN_MOD = 4'd4,
        FN_CMP = 4'd5,
        FN_OR  = 4'd8,
        FN_AND = 4'd9,
        FN_BIC = 4'd10,
        FN_XOR = 4'd11,
        FN_LSH = 4'd12,
        FN_ASH = 4'd13,
        FN_CHK = 4'd14
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    use_imm;
        logic    legal;
        logic    is_shift;
        logic    is_divmod;
        logic    is_check;
    } alu_dec_t;

endpackage

// File: rtl/alu_ri_opdecode.sv
// Module: opcode decoder. Splits the opcode into function code and
// immediate select, and classifies the function. Assumes OP_W >= IMM_SEL+2;
// every opcode bit above the immediate select must be zero for a legal op.
module alu_ri_opdecode
    import alu_ri_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] op_i,
    output alu_dec_t        dec_o
);
    localparam int HI_LSB = IMM_SEL + 1;

    logic            hi_clear;
    logic [FN_W-1:0] fn_raw;
    logic            fn_known;

    // Purpose: reject any opcode with a bit set above the immediate select.
    always_comb begin
        hi_clear = (op_i[OP_W-1:HI_LSB] == '0);
    end

    // Purpose: recognise the assigned function codes.
    always_comb begin
        fn_raw = op_i[FN_W-1:0];
        unique case (fn_raw)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5,
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14: fn_known = 1'b1;
            default:                                        fn_known = 1'b0;
        endcase
    end

    // Purpose: assemble the decode record used by the datapath.
    always_comb begin
        dec_o.fn        = alu_fn_e'(fn_raw);
        dec_o.use_imm   = op_i[IMM_SEL];
        dec_o.legal     = hi_clear && fn_known;
        dec_o.is_shift  = (fn_raw == FN_LSH) || (fn_raw == FN_ASH);
        dec_o.is_divmod = (fn_raw == FN_DIV) || (fn_raw == FN_MOD);
        dec_o.is_check  = (fn_raw == FN_CHK);
    end

endmodule

// File: rtl/alu_ri_shift.sv
// Module: signed-amount shifter. A non-negative amount shifts left; a
// negative amount shifts right by its magnitude, filling with zero or with
// the sign bit. Assumes a two's-complement amount of the data width; any
// magnitude above W-1 is reported as out of range.
module alu_ri_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] amt_i,
    input  logic         arith_i,
    output logic [W-1:0] res_o,
    output logic         bad_o
);
    localparam int SH_MAX  = W - 1;
    localparam int SH_BITS = $clog2(W);

    logic [W-1:0]       amt_neg;
    logic [SH_BITS-1:0] mag;
    logic               go_right;

    // Purpose: flag amounts outside -SH_MAX .. +SH_MAX.
    always_comb begin
        bad_o = ($signed(amt_i) > $signed(SH_MAX)) ||
                ($signed(amt_i) < $signed(-SH_MAX));
    end

    // Purpose: derive the shift direction and magnitude.
    always_comb begin
        amt_neg  = -amt_i;
        go_right = amt_i[W-1];
        mag      = go_right ? amt_neg[SH_BITS-1:0] : amt_i[SH_BITS-1:0];
    end

    // Purpose: select the shifted value; zero when the amount is illegal.
    always_comb begin
        if (bad_o) begin
            res_o = '0;
        end else if (!go_right) begin
            res_o = val_i << mag;
        end else if (arith_i) begin
            res_o = W'($signed(val_i) >>> mag);
        end else begin
            res_o = val_i >> mag;
        end
    end

endmodule

// File: rtl/alu_ri_floordiv.sv
// Module: floor-rounded signed divider. Returns a quotient rounded toward
// negative infinity and the remainder that matches it. Assumes two's
// complement; the most-negative / -1 case wraps to the most-negative value
// with remainder zero. A zero divisor returns zeros and raises zero_o.
module alu_ri_floordiv #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         zero_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] tq;
    logic signed [W-1:0] tr;
    logic                wrap_case;

    // Purpose: detect the two operand pairs that bypass the divider.
    always_comb begin
        zero_o    = (den_i == '0);
        wrap_case = (num_i == MOST_NEG) && (den_i == '1);
    end

    // Purpose: truncating division followed by a floor correction.
    always_comb begin
        tq    = '0;
        tr    = '0;
        quo_o = '0;
        rem_o = '0;
        if (zero_o) begin
            quo_o = '0;
            rem_o = '0;
        end else if (wrap_case) begin
            quo_o = MOST_NEG;
            rem_o = '0;
        end else begin
            tq = $signed(num_i) / $signed(den_i);
            tr = $signed(num_i) % $signed(den_i);
            if ((tr != '0) && (tr[W-1] != den_i[W-1])) begin
                quo_o = W'(tq - 1);
                rem_o = W'(tr + $signed(den_i));
            end else begin
                quo_o = tq;
                rem_o = tr;
            end
        end
    end

endmodule

// File: rtl/alu_ri_core.sv
// Module: top of the register-immediate integer ALU. Purely combinational:
// decodes the opcode, forms the second operand, runs the selected function
// and reports write enable, error and trap. Assumes IMM_W < DATA_W and a
// caller that commits result_o only while wr_en_o is high.
module alu_ri_core
    import alu_ri_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OP_W   = 6
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] ra_i,
    input  logic [DATA_W-1:0] rb_i,
    input  logic [DATA_W-1:0] rc_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              err_o,
    output logic              trap_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    alu_dec_t          dec;
    logic [DATA_W-1:0] opnd_c;
    logic [DATA_W-1:0] sh_res;
    logic              sh_bad;
    logic [DATA_W-1:0] dv_quo;
    logic [DATA_W-1:0] dv_rem;
    logic              dv_zero;
    logic [DATA_W:0]   cmp_diff;
    logic [DATA_W-1:0] raw_res;
    logic              opnd_bad;
    logic              chk_fail;

    alu_ri_opdecode #(.OP_W(OP_W)) u_dec (
        .op_i  (op_i),
        .dec_o (dec)
    );

    // Purpose: choose the second operand from the register or the immediate.
    always_comb begin
        if (dec.use_imm) begin
            opnd_c = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin
            opnd_c = rc_i;
        end
    end

    alu_ri_shift #(.W(DATA_W)) u_shift (
        .val_i   (rb_i),
        .amt_i   (opnd_c),
        .arith_i (dec.fn == FN_ASH),
        .res_o   (sh_res),
        .bad_o   (sh_bad)
    );

    alu_ri_floordiv #(.W(DATA_W)) u_div (
        .num_i  (rb_i),
        .den_i  (opnd_c),
        .quo_o  (dv_quo),
        .rem_o  (dv_rem),
        .zero_o (dv_zero)
    );

    // Purpose: exact difference one bit wider than the data, for compare.
    always_comb begin
        cmp_diff = {rb_i[DATA_W-1], rb_i} - {opnd_c[DATA_W-1], opnd_c};
    end

    // Purpose: bounds-check outcome on the signed value and limit.
    always_comb begin
        chk_fail = ra_i[DATA_W-1] || ($signed(ra_i) >= $signed(opnd_c));
    end

    // Purpose: function select for the raw result.
    always_comb begin
        unique case (dec.fn)
            FN_ADD:  raw_res = rb_i + opnd_c;
            FN_SUB:  raw_res = rb_i - opnd_c;
            FN_MUL:  raw_res = rb_i * opnd_c;
            FN_DIV:  raw_res = dv_quo;
            FN_MOD:  raw_res = dv_rem;
            FN_CMP: begin
                if (cmp_diff[DATA_W]) begin
                    raw_res = '1;
                end else if (cmp_diff == '0) begin
                    raw_res = '0;
                end else begin
                    raw_res = DATA_W'(1);
                end
            end
            FN_OR:   raw_res = rb_i | opnd_c;
            FN_AND:  raw_res = rb_i & opnd_c;
            FN_BIC:  raw_res = rb_i & ~opnd_c;
            FN_XOR:  raw_res = rb_i ^ opnd_c;
            FN_LSH,
            FN_ASH:  raw_res = sh_res;
            default: raw_res = '0;
        endcase
    end

    // Purpose: operand legality for the functions that can reject operands.
    always_comb begin
        opnd_bad = (dec.is_shift && sh_bad) || (dec.is_divmod && dv_zero);
    end

    // Purpose: final flags and result gating.
    always_comb begin
        err_o    = !dec.legal || opnd_bad;
        trap_o   = dec.legal && dec.is_check && chk_fail;
        wr_en_o  = !err_o && !dec.is_check;
        result_o = wr_en_o ? raw_res : '0;
    end

endmodule

// File: rtl/alu_ri_checker.sv
// Module: assertion checker for alu_ri_core, attached by bind. Classifies
// the opcode from its raw bits on its own and relates it to the outputs.
module alu_ri_checker #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OP_W   = 6
) (
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] ra_i,
    input logic [DATA_W-1:0] rb_i,
    input logic [DATA_W-1:0] rc_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              err_o,
    input logic              trap_o
);
    logic              upper_zero;
    logic [3:0]        fcode;
    logic              unassigned;
    logic [DATA_W-1:0] c_val;

    // Purpose: independent opcode classification for the properties.
    always_comb begin
        upper_zero = (op_i[OP_W-1:5] == '0);
        fcode      = op_i[3:0];
        unassigned = !upper_zero || (fcode == 4'd6) || (fcode == 4'd7) ||
                     (fcode == 4'd15);
        c_val      = op_i[4] ? {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rc_i;
    end

    // Purpose: output relations that hold for every input combination.
    always_comb begin
        if (err_o) begin
            a_r11_err_zero_result: assert (result_o == '0)
                else $error("error flag with nonzero result");
        end
        if (wr_en_o) begin
            a_r9_write_exclusive: assert (!err_o && !trap_o)
                else $error("write enable with error or trap");
        end
        if (trap_o) begin
            a_r9_trap_only_check: assert (upper_zero && fcode == 4'd14)
                else $error("trap from a non-check opcode");
        end
        if (unassigned) begin
            a_r10_unassigned_err: assert (err_o && !wr_en_o)
                else $error("unassigned opcode accepted");
        end
        if (upper_zero && fcode == 4'd5) begin
            a_r3_cmp_range: assert (result_o == '1 || result_o == '0 ||
                                    result_o == DATA_W'(1))
                else $error("compare outside -1..+1");
        end
        if (upper_zero && (fcode == 4'd12 || fcode == 4'd13) &&
            ($signed(c_val) > 31 || $signed(c_val) < -31)) begin
            a_r6_shift_range: assert (err_o)
                else $error("out-of-range shift accepted");
        end
        if (upper_zero && (fcode == 4'd3 || fcode == 4'd4) && c_val == '0) begin
            a_r8_div_zero: assert (err_o)
                else $error("division by zero accepted");
        end
    end

endmodule

bind alu_ri_core alu_ri_checker #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .OP_W   (OP_W)
) u_chk (.*);

// File: tb/alu_ri_core_tb.sv
module alu_ri_core_tb;

    localparam logic [5:0] O_ADD = 6'd0,  O_SUB = 6'd1,  O_MUL = 6'd2;
    localparam logic [5:0] O_DIV = 6'd3,  O_MOD = 6'd4,  O_CMP = 6'd5;
    localparam logic [5:0] O_OR  = 6'd8,  O_AND = 6'd9,  O_BIC = 6'd10;
    localparam logic [5:0] O_XOR = 6'd11, O_LSH = 6'd12, O_ASH = 6'd13;
    localparam logic [5:0] O_CHK = 6'd14, IMMF  = 6'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op;
    logic [31:0] ra, rb, rc;
    logic [15:0] imm;
    logic [31:0] res;
    logic        wr, err, trap;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    alu_ri_core u_dut (
        .op_i(op), .ra_i(ra), .rb_i(rb), .rc_i(rc), .imm_i(imm),
        .result_o(res), .wr_en_o(wr), .err_o(err), .trap_o(trap)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Drive after a rising edge; sample at the following falling edge.
    task automatic apply(input logic [5:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c,
                         input logic [15:0] i);
        @(posedge clk);
        #1;
        op = o; ra = a; rb = b; rc = c; imm = i;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [31:0] e_res,
                              input logic e_wr, input logic e_err,
                              input logic e_trap);
        n_chk = n_chk + 1;
        if (res !== e_res || wr !== e_wr || err !== e_err || trap !== e_trap) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual res=%h wr=%b err=%b trap=%b expected res=%h wr=%b err=%b trap=%b",
                     tag, res, wr, err, trap, e_res, e_wr, e_err, e_trap);
        end
    endtask

    task automatic t_idle;
        apply(O_ADD, 0, 0, 0, 0);
        expect_out("R11 idle add of zeros", 32'h0, 1, 0, 0);
    endtask

    task automatic t_arith;
        apply(O_ADD, 0, 5, 7, 16'h1234);
        expect_out("R2 add", 32'd12, 1, 0, 0);
        apply(O_ADD, 0, 32'h7FFF_FFFF, 1, 0);
        expect_out("R2 add wraps, no error", 32'h8000_0000, 1, 0, 0);
        apply(O_SUB, 0, 3, 10, 0);
        expect_out("R2 sub", 32'hFFFF_FFF9, 1, 0, 0);
        apply(O_MUL, 0, 32'h0001_0000, 32'h0001_0000, 0);
        expect_out("R2 mul low bits", 32'h0, 1, 0, 0);
        apply(O_MUL, 0, 32'hFFFF_FFFD, 7, 0);
        expect_out("R2 mul signed", 32'hFFFF_FFEB, 1, 0, 0);
    endtask

    task automatic t_immediate;
        apply(O_ADD | IMMF, 0, 10, 100, 16'hFFFF);
        expect_out("R1 addi sign-extended -1, rc ignored", 32'd9, 1, 0, 0);
        apply(O_OR | IMMF, 0, 0, 32'hFFFF_FFFF, 16'h8001);
        expect_out("R1 ori sign extension", 32'hFFFF_8001, 1, 0, 0);
        apply(O_ADD, 0, 1, 1, 16'h7FFF);
        expect_out("R1 register form ignores imm", 32'd2, 1, 0, 0);
    endtask

    task automatic t_compare;
        apply(O_CMP, 0, 5, 9, 0);
        expect_out("R3 cmp less", 32'hFFFF_FFFF, 1, 0, 0);
        apply(O_CMP, 0, 9, 9, 0);
        expect_out("R3 cmp equal", 32'h0, 1, 0, 0);
        apply(O_CMP, 0, 9, 5, 0);
        expect_out("R3 cmp greater", 32'h1, 1, 0, 0);
        apply(O_CMP, 0, 32'h8000_0000, 1, 0);
        expect_out("R3 cmp exact sign at negative wrap", 32'hFFFF_FFFF, 1, 0, 0);
        apply(O_CMP | IMMF, 0, 32'h7FFF_FFFF, 0, 16'hFFFF);
        expect_out("R3 cmpi exact sign at positive wrap", 32'h1, 1, 0, 0);
    endtask

    task automatic t_logic;
        apply(O_OR, 0, 32'h0000_F0F0, 32'h0000_0F00, 0);
        expect_out("R4 or", 32'h0000_FFF0, 1, 0, 0);
        apply(O_AND, 0, 32'hFF00_FF00, 32'h0FF0_0FF0, 0);
        expect_out("R4 and", 32'h0F00_0F00, 1, 0, 0);
        apply(O_BIC, 0, 32'hFFFF_FFFF, 32'h0000_00F0, 0);
        expect_out("R4 bit-clear", 32'hFFFF_FF0F, 1, 0, 0);
        apply(O_XOR, 0, 32'hAAAA_5555, 32'hFFFF_0000, 0);
        expect_out("R4 xor", 32'h5555_5555, 1, 0, 0);
    endtask

    task automatic t_shift;
        apply(O_LSH, 0, 1, 31, 0);
        expect_out("R5 lsh left 31", 32'h8000_0000, 1, 0, 0);
        apply(O_LSH, 0, 32'h8000_0000, 32'hFFFF_FFE1, 0);
        expect_out("R5 lsh right 31", 32'h1, 1, 0, 0);
        apply(O_LSH, 0, 32'hF000_0000, 32'hFFFF_FFFC, 0);
        expect_out("R5 lsh right zero fill", 32'h0F00_0000, 1, 0, 0);
        apply(O_ASH, 0, 32'hF000_0000, 32'hFFFF_FFFC, 0);
        expect_out("R5 ash right sign fill", 32'hFF00_0000, 1, 0, 0);
        apply(O_ASH | IMMF, 0, 32'h0000_0040, 0, 16'hFFFD);
        expect_out("R5 ashi right positive", 32'h8, 1, 0, 0);
        apply(O_ASH, 0, 32'h0000_0003, 2, 0);
        expect_out("R5 ash left", 32'hC, 1, 0, 0);
        apply(O_LSH, 0, 32'h1234_5678, 0, 0);
        expect_out("R5 shift by zero", 32'h1234_5678, 1, 0, 0);
        apply(O_LSH, 0, 1, 32, 0);
        expect_out("R6 shift +32 illegal", 32'h0, 0, 1, 0);
        apply(O_ASH | IMMF, 0, 32'h8000_0000, 0, 16'hFFE0);
        expect_out("R6 shift -32 illegal", 32'h0, 0, 1, 0);
    endtask

    task automatic t_divmod;
        apply(O_DIV, 0, 7, 2, 0);
        expect_out("R7 div 7/2", 32'd3, 1, 0, 0);
        apply(O_DIV, 0, -32'sd7, 2, 0);
        expect_out("R7 div -7/2 floors", -32'sd4, 1, 0, 0);
        apply(O_DIV, 0, 7, -32'sd2, 0);
        expect_out("R7 div 7/-2 floors", -32'sd4, 1, 0, 0);
        apply(O_DIV, 0, -32'sd7, -32'sd2, 0);
        expect_out("R7 div -7/-2", 32'd3, 1, 0, 0);
        apply(O_DIV, 0, -32'sd6, 3, 0);
        expect_out("R7 div exact negative", -32'sd2, 1, 0, 0);
        apply(O_MOD, 0, 7, 2, 0);
        expect_out("R7 mod 7,2", 32'd1, 1, 0, 0);
        apply(O_MOD, 0, -32'sd7, 2, 0);
        expect_out("R7 mod -7,2 sign of divisor", 32'd1, 1, 0, 0);
        apply(O_MOD, 0, 7, -32'sd2, 0);
        expect_out("R7 mod 7,-2 sign of divisor", -32'sd1, 1, 0, 0);
        apply(O_MOD, 0, -32'sd7, -32'sd2, 0);
        expect_out("R7 mod -7,-2", -32'sd1, 1, 0, 0);
        apply(O_MOD | IMMF, 0, 6, 0, 16'hFFFD);
        expect_out("R7 modi exact", 32'd0, 1, 0, 0);
        apply(O_DIV, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        expect_out("R7 div most-negative by -1", 32'h8000_0000, 1, 0, 0);
        apply(O_MOD, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        expect_out("R7 mod most-negative by -1", 32'h0, 1, 0, 0);
        apply(O_DIV, 0, 5, 0, 0);
        expect_out("R8 div by zero", 32'h0, 0, 1, 0);
        apply(O_MOD | IMMF, 0, 5, 3, 16'h0000);
        expect_out("R8 modi by zero", 32'h0, 0, 1, 0);
    endtask

    task automatic t_bounds;
        apply(O_CHK, 5, 32'hDEAD_BEEF, 10, 0);
        expect_out("R9 check inside", 32'h0, 0, 0, 0);
        apply(O_CHK, 9, 0, 10, 0);
        expect_out("R9 check top edge inside", 32'h0, 0, 0, 0);
        apply(O_CHK, 10, 0, 10, 0);
        expect_out("R9 check equal to limit traps", 32'h0, 0, 0, 1);
        apply(O_CHK, 32'hFFFF_FFFF, 0, 10, 0);
        expect_out("R9 check negative traps", 32'h0, 0, 0, 1);
        apply(O_CHK | IMMF, 0, 0, 0, 16'h0001);
        expect_out("R9 checki zero inside", 32'h0, 0, 0, 0);
        apply(O_CHK | IMMF, 3, 0, 100, 16'h0002);
        expect_out("R9 checki uses immediate limit", 32'h0, 0, 0, 1);
    endtask

    task automatic t_unassigned;
        logic [5:0] bad_ops [8] = '{6'd6, 6'd7, 6'd15, 6'd22, 6'd23, 6'd31, 6'd32, 6'd63};
        for (int k = 0; k < 8; k++) begin
            apply(bad_ops[k], 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222, 16'h0001);
            expect_out($sformatf("R10 unassigned opcode %0d", bad_ops[k]), 32'h0, 0, 1, 0);
        end
        apply(6'd32 | O_ADD, 0, 5, 7, 0);
        expect_out("R10 add code with bit 5 set", 32'h0, 0, 1, 0);
    endtask

    initial begin
        op = O_ADD; ra = '0; rb = '0; rc = '0; imm = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_arith();
        t_immediate();
        t_compare();
        t_logic();
        t_shift();
        t_divmod();
        t_bounds();
        t_unassigned();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule